// File: doc/BRIEF.md
# Iterative Multiply-Accumulate with Word Carry

This block computes `a * b + c` for three unsigned W-bit operands and returns the full 2W-bit result as two words. The low word goes to `res_lo` and the high word to `res_hi`. The addend `c` enters at weight one and is zero-extended. The sum therefore never needs more than 2W bits, and `res_hi` carries a whole word of carry into the next operation.

The main use is a scalar-by-vector big-integer multiply. Software feeds each vector word as `a`, the scalar as `b` and the previous `res_hi` as `c`, starting from zero. Each `res_lo` is one word of the product, and the final `res_hi` is its top word.

Each operation is a short sequence. A `start` pulse captures the operands. The multiplier is consumed `DIGIT_BITS` bits per cycle. The product register is preloaded with `c` in its upper half, so the addend costs no extra cycle. `busy` covers the iteration and `done` marks completion.

Top module: `wide_muladd`

## Requirements
- R1: After an operation, `res_lo` equals `(a*b + c) mod 2^W`, with `c` added unshifted and zero-extended.
- R2: After an operation, `res_hi` equals `floor((a*b + c) / 2^W)`.
- R3: With all operands at their maximum, the sum fits in 2W bits: `res_hi` is all ones and `res_lo` is zero. No intermediate sum overflows its register.
- R4: `start` is accepted at a rising edge where `busy` is low. `busy` is high from the next cycle. `done` is high for exactly the one cycle that follows the W/DIGIT_BITS-th rising edge after acceptance, and `busy` is low in that cycle.
- R5: `start` is ignored while `busy` is high. The running result is not disturbed and no extra `done` pulse appears.
- R6: `res_lo` and `res_hi` change only at completion. They hold their values after `done`, including throughout the next operation.
- R7: While `rst_n` is low and after its release, `busy` and `done` are low and both results are zero.
- R8: Feeding each `res_hi` back as the next `c` (first `c` = 0) yields the words of a multi-word scalar-by-vector product, least significant first. The last `res_hi` is the top word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| op_c | input | W | Addend / incoming word carry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | W | Low word of a*b+c |
| res_hi | output | W | High word of a*b+c (outgoing carry) |

## Verification
The failure modes differ in how soon they reach the ports. A wrong step count shows at once as a `done` pulse in the wrong cycle. A wrong digit weight or a dropped guard bit shows only in the result words, and only for operand patterns that exercise the affected digits. That is why a near-complete sweep over a narrow width is used.

A lost or misplaced addend corrupts `res_hi`, and through chaining it also corrupts every later word. Chained runs compared against a whole-number product expose it within one operation. A start that leaks in while busy shows as a changed result or a second `done` a few cycles later.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

  // Number of iterations needed to consume a w-bit multiplier db bits at a time.
  function automatic int unsigned wmac_steps(input int unsigned w, input int unsigned db);
    return (w + db - 1) / db;
  endfunction

  // Width of an iteration counter able to hold steps-1.
  function automatic int unsigned wmac_cnt_width(input int unsigned steps);
    return (steps > 2) ? $clog2(steps) : 1;
  endfunction

endpackage

// File: rtl/wmac_ctrl.sv
module wmac_ctrl #(
  parameter int unsigned STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  import wmac_pkg::*;

  localparam int unsigned CW = wmac_cnt_width(STEPS);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign busy   = busy_q;
  assign done   = done_q;
  assign load   = start && !busy_q;
  assign step   = busy_q;
  assign finish = busy_q && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= finish;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_FINISH_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));  // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> (busy && !done));  // R5

endmodule

// File: rtl/wmac_pp.sv
module wmac_pp #(
  parameter int unsigned W  = 64,
  parameter int unsigned DB = 2
) (
  input  logic [W-1:0]    mcand,
  input  logic [DB-1:0]   digit,
  output logic [W+DB-1:0] pp
);

  generate
    if (DB == 1) begin : g_radix2
      assign pp = digit[0] ? {1'b0, mcand} : '0;
    end else if (DB == 2) begin : g_radix4
      function automatic logic [W+1:0] radix4_term(input logic [W-1:0] m, input logic [1:0] d);
        logic [W+1:0] t1;
        logic [W+1:0] t2;
        t1 = {2'b00, m} & {(W+2){d[0]}};
        t2 = {1'b0, m, 1'b0} & {(W+2){d[1]}};
        return t1 + t2;
      endfunction
      assign pp = radix4_term(mcand, digit);
    end else begin : g_generic
      assign pp = (W+DB)'(mcand) * (W+DB)'(digit);
    end
  endgenerate

endmodule

// File: rtl/wmac_datapath.sv
module wmac_datapath #(
  parameter int unsigned W  = 64,
  parameter int unsigned DB = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         finish,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);

  logic [W-1:0]    mcand_q;
  logic [W-1:0]    hi_q;
  logic [W-1:0]    lo_q;
  logic [W-1:0]    res_lo_q;
  logic [W-1:0]    res_hi_q;
  logic [W+DB-1:0] pp;
  logic [W+DB:0]   sum_x;
  logic [W-1:0]    nxt_hi;
  logic [W-1:0]    nxt_lo;

  wmac_pp #(.W(W), .DB(DB)) u_pp (
    .mcand (mcand_q),
    .digit (lo_q[DB-1:0]),
    .pp    (pp)
  );

  // Upper half accumulates the digit term, then the pair shifts right by DB.
  assign sum_x  = {{(DB+1){1'b0}}, hi_q} + {1'b0, pp};
  assign nxt_hi = sum_x[W+DB-1:DB];
  assign nxt_lo = {sum_x[DB-1:0], lo_q[W-1:DB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      res_lo_q <= '0;
      res_hi_q <= '0;
    end else begin
      if (load) begin
        mcand_q <= a;
        hi_q    <= c;   // addend enters at weight 2^0 after W bits of shifting
        lo_q    <= b;
      end else if (step) begin
        hi_q    <= nxt_hi;
        lo_q    <= nxt_lo;
      end
      if (finish) begin
        res_lo_q <= nxt_lo;
        res_hi_q <= nxt_hi;
      end
    end
  end

  assign res_lo = res_lo_q;
  assign res_hi = res_hi_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum_x[W+DB]);  // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> ($stable(res_lo) && $stable(res_hi)));  // R6
  AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !finish) |=> $stable(mcand_q));  // R5

endmodule

// File: rtl/wide_muladd.sv
module wide_muladd #(
  parameter int unsigned W          = 64,
  parameter int unsigned DIGIT_BITS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  import wmac_pkg::*;

  localparam int unsigned STEPS = wmac_steps(W, DIGIT_BITS);

  logic acc_load;
  logic acc_step;
  logic acc_finish;

  wmac_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (acc_load),
    .step   (acc_step),
    .finish (acc_finish),
    .busy   (busy),
    .done   (done)
  );

  wmac_datapath #(.W(W), .DB(DIGIT_BITS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (acc_load),
    .step   (acc_step),
    .finish (acc_finish),
    .a      (op_a),
    .b      (op_b),
    .c      (op_c),
    .res_lo (res_lo),
    .res_hi (res_hi)
  );

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |-> (!busy && start));  // R4
  AST_LOAD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |=> (busy && !done));  // R4

endmodule

// File: tb/test_wide_muladd.sv
`timescale 1ns/1ps
module test_wide_muladd;

  localparam int unsigned W     = 6;
  localparam int unsigned DB    = 2;
  localparam int unsigned STEPS = W / DB;
  localparam longint      MASK  = (64'sd1 <<< W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] op_c = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] res_lo;
  logic [W-1:0] res_hi;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wide_muladd #(.W(W), .DIGIT_BITS(DB)) i_wide_muladd (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one operation; returns results and the number of negedges until done.
  task automatic run_op(input longint a, input longint b, input longint c,
                        output longint lo, output longint hi, output int lat);
    @(negedge clk);
    start = 1'b1;
    op_a = a[W-1:0]; op_b = b[W-1:0]; op_c = c[W-1:0];
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    lo = longint'(res_lo);
    hi = longint'(res_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint lo, hi, full, lo1, hi1;
    int lat;
    int bad_lo, bad_hi;

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 busy in reset", longint'(busy), 0);
    chk("R7 done in reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 busy after reset", longint'(busy), 0);
    chk("R7 done after reset", longint'(done), 0);
    chk("R7 results after reset", longint'({res_hi, res_lo}), 0);

    // R4: handshake timing
    @(negedge clk);
    start = 1'b1; op_a = 6'd5; op_b = 6'd9; op_c = 6'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after accept", longint'(busy), 1);
    chk("R4 done low while busy", longint'(done), 0);
    repeat (STEPS - 1) @(negedge clk);
    chk("R4 done still low before last step", longint'(done), 0);
    @(negedge clk);
    chk("R4 done pulse", longint'(done), 1);
    chk("R4 busy low at done", longint'(busy), 0);
    chk("R1 small product lo", longint'(res_lo), (5*9+1) & MASK);
    @(negedge clk);
    chk("R4 done one cycle only", longint'(done), 0);

    // R1/R2: near-exhaustive sweep of a and b, varying c
    bad_lo = 0; bad_hi = 0;
    for (int a = 0; a <= int'(MASK); a++) begin
      for (int b = 0; b <= int'(MASK); b++) begin
        longint c;
        c = longint'((a * 7 + b * 13 + 3) & int'(MASK));
        run_op(a, b, c, lo, hi, lat);
        full = longint'(a) * longint'(b) + c;
        if (lo != (full & MASK)) bad_lo++;
        if (hi != (full >>> W)) bad_hi++;
        if (lat != STEPS + 1) bad_hi++;
      end
    end
    chk("R1 sweep low-word mismatches", bad_lo, 0);
    chk("R2 sweep high-word and latency mismatches", bad_hi, 0);

    // R1/R2: every addend with a fixed mid pattern
    bad_lo = 0;
    for (int c = 0; c <= int'(MASK); c++) begin
      run_op(37, 22, c, lo, hi, lat);
      full = 37 * 22 + c;
      if (lo != (full & MASK) || hi != (full >>> W)) bad_lo++;
    end
    chk("R1 R2 addend sweep mismatches", bad_lo, 0);

    // R3: extreme operands
    run_op(MASK, MASK, MASK, lo, hi, lat);
    chk("R3 max operands hi", hi, MASK);
    chk("R3 max operands lo", lo, 0);
    run_op(MASK, MASK, 0, lo, hi, lat);
    chk("R3 max product hi", hi, MASK - 1);
    chk("R3 max product lo", lo, 1);
    run_op(0, 0, MASK, lo, hi, lat);
    chk("R1 addend only lo", lo, MASK);
    chk("R2 addend only hi", hi, 0);

    // R5: start held during busy with other operands
    @(negedge clk);
    start = 1'b1; op_a = 6'd45; op_b = 6'd51; op_c = 6'd12;
    @(negedge clk);
    op_a = 6'd1; op_b = 6'd1; op_c = 6'd0;
    @(negedge clk);
    op_a = 6'd2; op_b = 6'd3;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R5 done after ignored starts", longint'(done), 1);
    full = 45 * 51 + 12;
    chk("R5 lo unaffected", longint'(res_lo), full & MASK);
    chk("R5 hi unaffected", longint'(res_hi), full >>> W);
    @(negedge clk);
    chk("R5 no second done", longint'(done), 0);
    chk("R5 not restarted", longint'(busy), 0);

    // R6: hold after done and during the next operation
    lo1 = longint'(res_lo); hi1 = longint'(res_hi);
    repeat (4) @(negedge clk);
    chk("R6 lo held idle", longint'(res_lo), lo1);
    chk("R6 hi held idle", longint'(res_hi), hi1);
    start = 1'b1; op_a = 6'd3; op_b = 6'd3; op_c = 6'd3;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R6 lo held while busy", longint'(res_lo), lo1);
    chk("R6 hi held while busy", longint'(res_hi), hi1);
    repeat (STEPS) @(negedge clk);
    chk("R6 new result after completion", longint'(res_lo), 12);

    // R8: chained scalar-by-vector products
    for (int pat = 0; pat < 6; pat++) begin
      longint s, carry, bigv, prod;
      longint v[6];
      int bad;
      s = (pat == 0) ? MASK : longint'((pat * 19 + 5) & int'(MASK));
      bigv = 0;
      for (int i = 0; i < 6; i++) begin
        v[i] = (pat == 0) ? MASK : longint'((pat * 11 + i * 29 + 7) & int'(MASK));
        bigv = bigv | (v[i] <<< (W * i));
      end
      prod = bigv * s;
      carry = 0;
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        run_op(v[i], s, carry, lo, hi, lat);
        if (lo != ((prod >>> (W * i)) & MASK)) bad++;
        carry = hi;
      end
      if (carry != ((prod >>> (W * 6)) & MASK)) bad++;
      chk("R8 chained word mismatches", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule